// File: doc/BRIEF.md
# MDIO Management Slave (PHY Side)

This block is the PHY end of a two-wire management bus. A station drives a slow management clock and a shared data line. The block oversamples both with its own system clock and decodes each serial frame bit by bit: a synchronising run of ones, a two-bit start marker, an operation code, a PHY address, a register index, a turnaround gap and a 16-bit data word. It keeps 32 registers of 16 bits each. A write updates one of them. A read returns one of them on the shared line.

Several PHYs can share the bus. The block acts only on frames whose address field equals its strap input, and stays passive for every other frame. When it answers a read, it takes over the line during the turnaround gap. It releases the line once the last data bit has been sent, so the line returns to its pulled-up idle level. Every write that is accepted also produces a one-cycle strobe, which carries the register index and the new value to the logic around the block.

Top module: `mdio_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive 1 bits, sampled on MDC rising edges, followed by a 0 and then a 1. A run of 31 ones followed by a valid-looking frame has no effect.
- R2: The two operation bits that follow the start marker select the action: 1 then 0 is a read, 0 then 1 is a write.
- R3: The 3-bit address field, sent MSB first, must equal `phy_addr_i`. Otherwise the block neither drives the line nor writes for the rest of that frame.
- R4: The 5-bit register field, sent MSB first, selects one of 32 registers of 16 bits. All registers are 0 after reset.
- R5: On a matching read, `mdio_oe_o` stays low during the first turnaround bit. During the second turnaround bit it is high with `mdio_o` at 0.
- R6: On a matching read, the 16 register bits follow the turnaround MSB first. Drive changes take effect only after an MDC falling edge, so each bit is stable at the next MDC rising edge.
- R7: During a write frame `mdio_oe_o` stays low. The 16 data bits after the two turnaround bits are captured MSB first.
- R8: After reset and between frames `mdio_oe_o` is low and `wr_strobe_o` is low.
- R9: An operation code of 00 or 11 aborts the frame. The block causes no write and no drive until a new preamble and start marker arrive.
- R10: After a full preamble, a start marker of 00 instead of 01 aborts the frame in the same way.
- R11: A matching write raises `wr_strobe_o` for exactly one clock after the 16th data bit is sampled. `wr_addr_o` and `wr_data_o` carry the register index and the data word during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples MDC and MDIO |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Sampled level of the shared data line |
| phy_addr_i | input | 3 | Strapped PHY address |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe_o | output | 1 | Drive enable for the data line; low means high impedance |
| wr_strobe_o | output | 1 | One-cycle pulse for each accepted write |
| wr_addr_o | output | 5 | Register index of the accepted write |
| wr_data_o | output | 16 | Data word of the accepted write |

## Verification
Each MDC edge passes through two synchroniser flops and reaches the decoder one clock later. The write strobe therefore appears about three system clocks after the MDC rising edge of the last data bit. A drive change appears about three clocks after an MDC falling edge. The bench holds each MDC phase for eight system clocks and samples the line just before it raises MDC, when the drive launched after the preceding falling edge has long settled. The write monitor pops its queue whenever the strobe occurs, so it does not depend on an exact latency. After every frame the bench checks how many strobes and how many driven cycles occurred, and any stray activity shows up there.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OPC,
    ST_PHY,
    ST_REG,
    ST_TURN,
    ST_DATA
  } frame_st_e;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o
);
  logic [SYNC-1:0] mdc_s, dio_s;
  logic            mdc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_s <= '0;
      dio_s <= '1;
      mdc_d <= 1'b0;
    end else begin
      mdc_s <= {mdc_s[SYNC-2:0], mdc_i};
      dio_s <= {dio_s[SYNC-2:0], mdio_i};
      mdc_d <= mdc_s[SYNC-1];
    end
  end

  assign rise_o = mdc_s[SYNC-1] & ~mdc_d;
  assign fall_o = ~mdc_s[SYNC-1] & mdc_d;
  assign bit_o  = dio_s[SYNC-1];
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slv_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_AW  = 3,
  parameter int REG_AW  = 5,
  parameter int DW      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              mdc_fall_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [DW-1:0]     rd_word_i,
  output logic [REG_AW-1:0] reg_idx_o,
  output logic              wr_en_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output frame_st_e         st_o,
  output logic              rd_op_o,
  output logic              addr_hit_o
);
  localparam int MAXC = (PRE_LEN > DW) ? PRE_LEN : DW;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PRE_DONE = CW'(PRE_LEN);
  localparam logic [CW-1:0] LAST_OP  = CW'(1);
  localparam logic [CW-1:0] LAST_PHY = CW'(PHY_AW - 1);
  localparam logic [CW-1:0] LAST_REG = CW'(REG_AW - 1);
  localparam logic [CW-1:0] LAST_TA  = CW'(1);
  localparam logic [CW-1:0] LAST_DAT = CW'(DW - 1);

  frame_st_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [DW-1:0]     sh_q, rd_sh_q, nxt_sh;
  logic [REG_AW-1:0] reg_q;
  logic              rd_q, hit_q, wr_q, oe_q, out_q;
  logic [DW-1:0]     wdat_q;

  assign nxt_sh = {sh_q[DW-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_sh_q <= '0;
      reg_q   <= '0;
      rd_q    <= 1'b0;
      hit_q   <= 1'b0;
      wr_q    <= 1'b0;
      wdat_q  <= '0;
    end else begin
      wr_q <= 1'b0;
      if (bit_vld_i) begin
        unique case (st_q)
          ST_HUNT: begin
            if (bit_i) begin
              if (cnt_q != PRE_DONE) cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              if (cnt_q == PRE_DONE) st_q <= ST_START;
            end
          end
          ST_START: begin
            cnt_q <= '0;
            st_q  <= bit_i ? ST_OPC : ST_HUNT;
          end
          ST_OPC: begin
            sh_q <= nxt_sh;
            if (cnt_q == LAST_OP) begin
              cnt_q <= '0;
              // 10 = read, 01 = write, others abort
              if (nxt_sh[1] ^ nxt_sh[0]) begin
                rd_q <= nxt_sh[1];
                st_q <= ST_PHY;
              end else begin
                st_q <= ST_HUNT;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PHY: begin
            sh_q <= nxt_sh;
            if (cnt_q == LAST_PHY) begin
              cnt_q <= '0;
              hit_q <= (nxt_sh[PHY_AW-1:0] == phy_addr_i);
              st_q  <= ST_REG;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_REG: begin
            sh_q <= nxt_sh;
            if (cnt_q == LAST_REG) begin
              cnt_q <= '0;
              reg_q <= nxt_sh[REG_AW-1:0];
              st_q  <= ST_TURN;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_TURN: begin
            if (cnt_q == '0) rd_sh_q <= rd_word_i;
            if (cnt_q == LAST_TA) begin
              cnt_q <= '0;
              st_q  <= ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            sh_q    <= nxt_sh;
            rd_sh_q <= {rd_sh_q[DW-2:0], 1'b0};
            if (cnt_q == LAST_DAT) begin
              cnt_q  <= '0;
              st_q   <= ST_HUNT;
              wr_q   <= ~rd_q & hit_q;
              wdat_q <= nxt_sh;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

  // launch drive on MDC falling edge so it settles before the next rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
    end else if (mdc_fall_i) begin
      oe_q  <= rd_q & hit_q &
               (((st_q == ST_TURN) && (cnt_q == LAST_TA)) || (st_q == ST_DATA));
      out_q <= (st_q == ST_DATA) & rd_sh_q[DW-1];
    end
  end

  assign reg_idx_o  = reg_q;
  assign wr_en_o    = wr_q;
  assign wr_data_o  = wdat_q;
  assign mdio_o     = out_q;
  assign mdio_oe_o  = oe_q;
  assign st_o       = st_q;
  assign rd_op_o    = rd_q;
  assign addr_hit_o = hit_q;
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_slv_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_AW  = 3,
  parameter int REG_AW  = 5,
  parameter int DW      = 16,
  parameter int SYNC    = 2,
  localparam int DEPTH  = 1 << REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdc_i,
  input  logic              mdio_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              wr_strobe_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o
);
  logic              mdc_rise, mdc_fall, smp_bit;
  logic [REG_AW-1:0] reg_idx;
  logic [DW-1:0]     rd_word, wr_word;
  logic              wr_en, rd_op, addr_hit;
  frame_st_e         frame_st;

  mdio_edge_sync #(.SYNC(SYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mdc_i (mdc_i),
    .mdio_i(mdio_i),
    .rise_o(mdc_rise),
    .fall_o(mdc_fall),
    .bit_o (smp_bit)
  );

  mdio_frame_fsm #(
    .PRE_LEN(PRE_LEN), .PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (mdc_rise),
    .bit_i     (smp_bit),
    .mdc_fall_i(mdc_fall),
    .phy_addr_i(phy_addr_i),
    .rd_word_i (rd_word),
    .reg_idx_o (reg_idx),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_word),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .st_o      (frame_st),
    .rd_op_o   (rd_op),
    .addr_hit_o(addr_hit)
  );

  mdio_reg_bank #(.DW(DW), .DEPTH(DEPTH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .idx_i  (reg_idx),
    .wdata_i(wr_word),
    .rdata_o(rd_word)
  );

  assign wr_strobe_o = wr_en;
  assign wr_addr_o   = reg_idx;
  assign wr_data_o   = wr_word;
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk
  import mdio_slv_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      mdio_o,
  input logic      mdio_oe_o,
  input logic      wr_strobe_o,
  input logic      mdc_fall,
  input frame_st_e frame_st,
  input logic      rd_op,
  input logic      addr_hit
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !wr_strobe_o); // R11

  AST_TA_DRIVE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_st == ST_TURN && mdio_oe_o) |-> !mdio_o); // R5

  AST_QUIET_UNLESS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> (rd_op && addr_hit)); // R3

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> !mdio_oe_o); // R7

  AST_OE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> $past(mdc_fall)); // R6
endmodule

bind mdio_slave mdio_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o),
  .wr_strobe_o(wr_strobe_o),
  .mdc_fall   (mdc_fall),
  .frame_st   (frame_st),
  .rd_op      (rd_op),
  .addr_hit   (addr_hit)
);

// File: tb/sim_mdio_slave.sv
`timescale 1ns/1ps
module sim_mdio_slave;
  localparam int HALF = 8;

  typedef struct packed {
    logic [4:0]  a;
    logic [15:0] d;
  } wr_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mdc = 1'b0;
  logic       m_oe = 1'b0;
  logic       m_bit = 1'b1;
  logic [2:0] strap = 3'd5;
  logic       s_out, s_oe, strb;
  logic [4:0] wa;
  logic [15:0] wd;
  logic       line;

  always #2.5 clk = ~clk;

  assign line = s_oe ? s_out : (m_oe ? m_bit : 1'b1);

  mdio_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .mdc_i(mdc), .mdio_i(line),
    .phy_addr_i(strap), .mdio_o(s_out), .mdio_oe_o(s_oe),
    .wr_strobe_o(strb), .wr_addr_o(wa), .wr_data_o(wd)
  );

  int checks = 0, fails = 0, strobes = 0, oe_cycles = 0;
  logic [15:0] model [32];
  wr_t exp_wr_q [$];
  logic [15:0] exp_rd_q [$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // write monitor
  always @(negedge clk) begin
    wr_t e;
    if (s_oe) oe_cycles++;
    if (strb) begin
      strobes++;
      if (exp_wr_q.size() == 0) chk(0, "R11", "unexpected strobe", {11'd0, wa, wd}, 0);
      else begin
        e = exp_wr_q.pop_front();
        chk(wa == e.a && wd == e.d, "R11", "strobe addr/data", {11'd0, wa, wd}, {11'd0, e.a, e.d});
      end
    end
  end

  // read monitor: collect after turnaround zero
  bit          col = 0;
  int          nbit = 0;
  logic [15:0] word;
  always @(posedge mdc) begin
    logic [15:0] e;
    if (!col) begin
      if (s_oe && !s_out) begin col = 1; nbit = 0; end
    end else begin
      word = {word[14:0], line};
      nbit++;
      if (nbit == 16) begin
        col = 0;
        if (exp_rd_q.size() == 0) chk(0, "R6", "unexpected read data", {16'd0, word}, 0);
        else begin
          e = exp_rd_q.pop_front();
          chk(word == e, "R6", "read data MSB first", {16'd0, word}, {16'd0, e});
        end
      end
    end
  end

  task automatic send_bit(input logic b, input logic drv, output logic o_oe, output logic o_out);
    @(negedge clk);
    mdc = 1'b0; m_oe = drv; m_bit = b;
    repeat (HALF) @(negedge clk);
    o_oe = s_oe; o_out = s_out;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                       input logic [2:0] phy, input logic [4:0] ra, input logic [15:0] d,
                       input bit release_line, output logic ta1_oe, output logic ta2_oe,
                       output logic ta2_out);
    logic x, y;
    for (int i = 0; i < pre; i++) send_bit(1'b1, 1'b1, x, y);
    for (int i = 1; i >= 0; i--) send_bit(st[i], 1'b1, x, y);
    for (int i = 1; i >= 0; i--) send_bit(op[i], 1'b1, x, y);
    for (int i = 2; i >= 0; i--) send_bit(phy[i], 1'b1, x, y);
    for (int i = 4; i >= 0; i--) send_bit(ra[i], 1'b1, x, y);
    if (release_line) begin
      send_bit(1'b1, 1'b0, ta1_oe, y);
      send_bit(1'b1, 1'b0, ta2_oe, ta2_out);
      for (int i = 15; i >= 0; i--) send_bit(1'b1, 1'b0, x, y);
    end else begin
      send_bit(1'b1, 1'b1, ta1_oe, y);
      send_bit(1'b0, 1'b1, ta2_oe, ta2_out);
      for (int i = 15; i >= 0; i--) send_bit(d[i], 1'b1, x, y);
    end
    send_bit(1'b1, 1'b0, x, y);
    send_bit(1'b1, 1'b0, x, y);
  endtask

  task automatic do_write(input logic [2:0] phy, input logic [4:0] ra, input logic [15:0] d);
    int s0;
    bit hit;
    logic a, b, c;
    hit = (phy == strap);
    if (hit) begin exp_wr_q.push_back({ra, d}); model[ra] = d; end
    s0 = strobes; oe_cycles = 0;
    frame(32, 2'b01, 2'b01, phy, ra, d, 0, a, b, c);
    repeat (4) @(negedge clk);
    if (hit) chk(strobes - s0 == 1, "R11", "one strobe per write", strobes - s0, 1);
    else     chk(strobes - s0 == 0, "R3", "foreign write ignored", strobes - s0, 0);
    chk(oe_cycles == 0, "R7", "no drive during write", oe_cycles, 0);
  endtask

  task automatic do_read(input logic [2:0] phy, input logic [4:0] ra);
    bit hit;
    logic t1, t2, t2o;
    hit = (phy == strap);
    if (hit) exp_rd_q.push_back(model[ra]);
    oe_cycles = 0;
    frame(32, 2'b01, 2'b10, phy, ra, 16'h0, 1, t1, t2, t2o);
    if (hit) begin
      chk(t1 == 1'b0, "R5", "turnaround bit 1 undriven", t1, 0);
      chk(t2 == 1'b1 && t2o == 1'b0, "R5", "turnaround bit 2 driven 0", {t2, t2o}, 2'b10);
      chk(exp_rd_q.size() == 0, "R6", "read word delivered", exp_rd_q.size(), 0);
      chk(s_oe == 1'b0, "R8", "line released after read", s_oe, 0);
    end else begin
      chk(oe_cycles == 0, "R3", "foreign read not driven", oe_cycles, 0);
    end
  endtask

  task automatic bad_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] ra, input string req);
    int s0;
    logic a, b, c;
    s0 = strobes; oe_cycles = 0;
    frame(pre, st, op, strap, ra, 16'hBEEF, 0, a, b, c);
    repeat (4) @(negedge clk);
    chk(strobes - s0 == 0, req, "aborted frame writes nothing", strobes - s0, 0);
    chk(oe_cycles == 0, req, "aborted frame drives nothing", oe_cycles, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic a, b;
    for (int i = 0; i < 32; i++) model[i] = 16'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(s_oe == 1'b0 && strb == 1'b0, "R8", "idle after reset", {s_oe, strb}, 0);

    do_read(3'd5, 5'd5);                      // R4 reset value 0
    do_write(3'd5, 5'd0, 16'hA5C3);           // R2 write, R4 low index
    do_write(3'd5, 5'd31, 16'h1234);          // R4 top index
    do_write(3'd5, 5'd7, 16'hFFFF);
    do_write(3'd5, 5'd8, 16'h0001);
    do_read(3'd5, 5'd0);                      // R2 read
    do_read(3'd5, 5'd31);
    do_read(3'd5, 5'd7);
    do_read(3'd5, 5'd8);

    do_write(3'd2, 5'd0, 16'h0000);           // R3 foreign write
    do_read(3'd2, 5'd0);                      // R3 foreign read
    do_read(3'd5, 5'd0);

    send_bit(1'b0, 1'b1, a, b);               // clear the ones count
    bad_frame(31, 2'b01, 2'b01, 5'd9, "R1");
    do_read(3'd5, 5'd9);                      // R1 still 0

    bad_frame(32, 2'b01, 2'b00, 5'd10, "R9");
    bad_frame(32, 2'b01, 2'b11, 5'd10, "R9");
    do_read(3'd5, 5'd10);
    bad_frame(32, 2'b00, 2'b01, 5'd11, "R10");
    do_read(3'd5, 5'd11);

    strap = 3'd2;                             // R3 new strap
    do_write(3'd2, 5'd3, 16'h5A5A);
    do_write(3'd5, 5'd3, 16'h0F0F);
    do_read(3'd2, 5'd3);

    repeat (10) @(negedge clk);
    chk(exp_wr_q.size() == 0, "R11", "all writes strobed", exp_wr_q.size(), 0);
    chk(s_oe == 1'b0 && strb == 1'b0, "R8", "idle at end", {s_oe, strb}, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule